// File: doc/BRIEF.md
# Output Watchdog Supervisor

This block guards a parallel digital output port against stalled software. A control register carries an enable flag and a sticky timeout flag. While the watchdog is enabled, every read or write strobe on the output data register restarts a countdown. When the countdown runs out, the block drives every output pin to its off level, raises the timeout flag and locks the output data register against writes.

Software recovers by writing a one to the timeout flag. This clears the flag and removes the lock. The pins still stay off until software performs a fresh write to the output data register. The timeout length is a parameter counted in clock cycles. By default it is computed from the clock frequency and a duration in microseconds, and a test can override it with a short value. Bus address decoding and the pin drivers sit outside the block. The block sees one write strobe for the control register, one read strobe and one write strobe for the output data register, and a shared write-data bus.

Top module: `outwd_supervisor`

## Requirements
- R1: After reset the enable flag (control bit 1) and the timeout flag (control bit 3) are 0, and every output pin is at the off level (0 by default).
- R2: A control write loads control bit 1 from write-data bit 1. A 1 enables the watchdog and a 0 disables it. The value reads back on `ctrl_status[1]` one cycle after the write.
- R3: A write to the output data register while the timeout flag is 0 shows on `out_pins` one cycle after the write.
- R4: With the watchdog enabled and no data access, the timeout flag rises exactly TIMEOUT_CYC cycles after the last access or enable write, and not one cycle earlier.
- R5: A data read or a data write restarts the countdown. An access in the same cycle as the final count cancels the timeout.
- R6: In the cycle the timeout flag rises, every output pin goes to the off level.
- R7: While the timeout flag is 1, data writes leave `out_pins` unchanged, and data reads do not clear the flag.
- R8: A control write with write-data bit 3 at 1 clears a set timeout flag. A control write with bit 3 at 0 leaves the flag unchanged.
- R9: After the timeout flag is cleared, the outputs stay at the off level until the next data write, and that write's value then appears.
- R10: While the watchdog is disabled, no timeout occurs and accesses do not change the timeout flag. The countdown is held cleared, so re-enabling gives a full TIMEOUT_CYC period.
- R11: All `ctrl_status` bits other than bits 1 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control register |
| data_wr | input | 1 | Write strobe for the output data register |
| data_rd | input | 1 | Read strobe for the output data register (restarts countdown) |
| wdata | input | DATA_W | Write data for both registers; control uses the low CTRL_W bits |
| out_pins | output | DATA_W | Output pin levels |
| ctrl_status | output | CTRL_W | Control register readback: bit 1 enable, bit 3 timeout flag |

## Verification
Two events can fall in the same cycle: a data access, and the countdown reaching its final value. The bench lets the watchdog run for exactly TIMEOUT_CYC-1 idle cycles and then issues a read in the next cycle. It judges the result by the timeout flag staying 0 and by a fresh full period being needed afterwards. A second pairing, a clear of the flag together with a data write, is produced by the random phase. A cycle-level reference model in the bench judges it: the write must still be refused, because the lock applies during the clearing cycle.

// File: rtl/outwd_pkg.sv
`timescale 1ns/1ps
package outwd_pkg;
   localparam int unsigned CTRL_W = 8;
   localparam int unsigned EN_BIT = 1;
   localparam int unsigned ST_BIT = 3;

   typedef struct packed {
      logic en;
      logic st;
   } wd_state_t;
endpackage

// File: rtl/wd_timer.sv
`timescale 1ns/1ps
module wd_timer #(
   parameter int unsigned TIMEOUT_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic kick,
   output logic expire
);
   localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          at_last;

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("wd_timer: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   assign at_last = (cnt_q == LAST);
   assign expire  = run & ~kick & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || kick) begin
         cnt_q <= '0;
      end else if (!at_last) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/wd_ctrl_reg.sv
`timescale 1ns/1ps
module wd_ctrl_reg
   import outwd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              expire,
   output wd_state_t         state,
   output logic [CTRL_W-1:0] ctrl_status
);
   logic en_q;
   logic st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (ctrl_wr) begin
         en_q <= wdata[EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= 1'b0;
      end else if (expire) begin
         st_q <= 1'b1;
      end else if (ctrl_wr && wdata[ST_BIT] && st_q) begin
         st_q <= 1'b0;
      end
   end

   assign state.en = en_q;
   assign state.st = st_q;

   generate
      for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
         if (b == EN_BIT) begin : g_en
            assign ctrl_status[b] = en_q;
         end else if (b == ST_BIT) begin : g_st
            assign ctrl_status[b] = st_q;
         end else begin : g_zero
            assign ctrl_status[b] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/wd_out_reg.sv
`timescale 1ns/1ps
module wd_out_reg #(
   parameter int unsigned DATA_W    = 16,
   parameter bit          OFF_LEVEL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   output logic [DATA_W-1:0] out_pins
);
   logic [DATA_W-1:0] data_q;
   logic              forced_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= {DATA_W{OFF_LEVEL}};
      end else if (wr_en) begin
         data_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         forced_q <= 1'b0;
      end else if (wr_en) begin
         forced_q <= 1'b0;
      end else if (expire) begin
         forced_q <= 1'b1;
      end
   end

   generate
      if (OFF_LEVEL) begin : g_off_high
         assign out_pins = data_q | {DATA_W{forced_q}};
      end else begin : g_off_low
         assign out_pins = data_q & ~{DATA_W{forced_q}};
      end
   endgenerate
endmodule

// File: rtl/outwd_supervisor.sv
`timescale 1ns/1ps
module outwd_supervisor
   import outwd_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned TIMEOUT_US  = 120_000,
   parameter int unsigned TIMEOUT_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US,
   parameter bit          OFF_LEVEL   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] out_pins,
   output logic [CTRL_W-1:0] ctrl_status
);
   wd_state_t state;
   logic      expire;
   logic      kick;
   logic      run;
   logic      wr_ok;

   generate
      if (DATA_W < CTRL_W) begin : g_bad_width
         $error("outwd_supervisor: DATA_W must be at least CTRL_W");
      end
   endgenerate

   assign kick  = data_wr | data_rd;
   assign run   = state.en & ~state.st;
   assign wr_ok = data_wr & ~state.st;

   wd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .kick   (kick),
      .expire (expire)
   );

   wd_ctrl_reg u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_wr     (ctrl_wr),
      .wdata       (wdata[CTRL_W-1:0]),
      .expire      (expire),
      .state       (state),
      .ctrl_status (ctrl_status)
   );

   wd_out_reg #(.DATA_W(DATA_W), .OFF_LEVEL(OFF_LEVEL)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ok),
      .wdata    (wdata),
      .expire   (expire),
      .out_pins (out_pins)
   );
endmodule

// File: rtl/outwd_supervisor_chk.sv
`timescale 1ns/1ps
module outwd_supervisor_chk
   import outwd_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter bit          OFF_LEVEL = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_wr,
   input logic              data_wr,
   input logic              data_rd,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] out_pins,
   input logic [CTRL_W-1:0] ctrl_status
);
   localparam logic [DATA_W-1:0] OFF_VEC = {DATA_W{OFF_LEVEL}};
   logic st;
   logic en;
   assign st = ctrl_status[ST_BIT];
   assign en = ctrl_status[EN_BIT];

   p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (en == $past(wdata[EN_BIT])));

   p_kick_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr || data_rd) |=> !$rose(st));

   p_off_on_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st) |-> (out_pins == OFF_VEC));

   p_locked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st && data_wr) |=> $stable(out_pins));

   p_locked_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st && data_rd && !ctrl_wr) |=> st);

   p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st && ctrl_wr && wdata[ST_BIT]) |=> !st);

   p_w0_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st && ctrl_wr && !wdata[ST_BIT]) |=> st);

   p_stay_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!st && out_pins == OFF_VEC && !data_wr) |=> (out_pins == OFF_VEC));

   p_no_timeout_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !$rose(st));

   p_spare_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ctrl_status) == $countones({st, en}));
endmodule

bind outwd_supervisor outwd_supervisor_chk #(
   .DATA_W    (DATA_W),
   .OFF_LEVEL (OFF_LEVEL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctrl_wr     (ctrl_wr),
   .data_wr     (data_wr),
   .data_rd     (data_rd),
   .wdata       (wdata),
   .out_pins    (out_pins),
   .ctrl_status (ctrl_status)
);

// File: tb/sim_outwd_supervisor.sv
`timescale 1ns/1ps
module sim_outwd_supervisor;
   localparam int unsigned W = 16;
   localparam int unsigned T = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctrl_wr = 1'b0;
   logic         data_wr = 1'b0;
   logic         data_rd = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] out_pins;
   logic [7:0]   ctrl_status;

   int checks = 0;
   int errors = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   // reference model state
   logic         m_en, m_st, m_off;
   logic [W-1:0] m_data;
   int           m_idle;

   always #5 clk = ~clk;

   outwd_supervisor #(.DATA_W(W), .TIMEOUT_CYC(T)) u0 (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
      .data_rd(data_rd), .wdata(wdata), .out_pins(out_pins),
      .ctrl_status(ctrl_status)
   );

   // expected control readback from model flags (bit1 enable, bit3 flag)
   function automatic logic [7:0] exp_ctrl(input logic en, input logic st);
      return {4'b0, st, 1'b0, en, 1'b0};
   endfunction

   function automatic logic [W-1:0] exp_pins(input logic off, input logic [W-1:0] d);
      return off ? '0 : d;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0; m_st = 0; m_off = 0; m_data = '0; m_idle = 0;
      end else begin
         logic acc, tout;
         acc  = data_wr | data_rd;
         tout = m_en && !m_st && !acc && (m_idle == T - 1);
         if (!m_en || m_st || acc) m_idle = 0;
         else if (m_idle < T - 1) m_idle = m_idle + 1;
         if (data_wr && !m_st) begin m_data = wdata; m_off = 0; end
         else if (tout) m_off = 1;
         if (tout) m_st = 1;
         else if (ctrl_wr && wdata[3] && m_st) m_st = 0;
         if (ctrl_wr) m_en = wdata[1];
      end
   end

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (model_on && rst_n) begin
         check("R3/R6/R7/R9 model pins", out_pins, exp_pins(m_off, m_data));
         check("R2/R4/R8/R11 model ctrl", W'(ctrl_status), W'(exp_ctrl(m_en, m_st)));
      end
   end

   task automatic cyc(input logic cw, input logic dw, input logic dr, input logic [W-1:0] wd);
      ctrl_wr = cw; data_wr = dw; data_rd = dr; wdata = wd;
      @(posedge clk);
      @(negedge clk);
      ctrl_wr = 0; data_wr = 0; data_rd = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, '0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      int unsigned seed;
      seed = 32'h1234_5678;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R1 pins after reset", out_pins, '0);
      check("R1 R11 ctrl after reset", W'(ctrl_status), '0);
      rst_n = 1;
      @(negedge clk);
      model_on = 1;

      cyc(0, 1, 0, 16'hA5A5);
      check("R3 write visible", out_pins, 16'hA5A5);
      idle(3 * T);
      check("R10 no timeout while disabled", W'(ctrl_status[3]), 0);

      cyc(1, 0, 0, 16'h0002);
      check("R2 R11 enable readback", W'(ctrl_status), 16'h0002);
      idle(T - 1);
      check("R4 not early", W'(ctrl_status[3]), 0);
      idle(1);
      check("R4 flag at TIMEOUT_CYC", W'(ctrl_status[3]), 1);
      check("R6 pins off", out_pins, '0);

      cyc(0, 1, 0, 16'h1234);
      check("R7 locked write ignored", out_pins, '0);
      cyc(0, 0, 1, '0);
      check("R7 read keeps flag", W'(ctrl_status[3]), 1);
      cyc(1, 0, 0, 16'h0002);
      check("R8 write 0 keeps flag", W'(ctrl_status[3]), 1);
      cyc(1, 0, 0, 16'h000A);
      check("R8 write 1 clears flag", W'(ctrl_status), 16'h0002);
      check("R9 pins still off after clear", out_pins, '0);
      idle(3);
      check("R9 pins off until write", out_pins, '0);
      cyc(0, 1, 0, 16'h5A5A);
      check("R9 R3 new write appears", out_pins, 16'h5A5A);

      idle(T - 1);
      cyc(0, 0, 1, '0);
      check("R5 read at final count cancels", W'(ctrl_status[3]), 0);
      idle(T - 1);
      check("R5 full period restarted", W'(ctrl_status[3]), 0);
      idle(1);
      check("R5 timeout after restart", W'(ctrl_status[3]), 1);

      cyc(1, 0, 0, 16'h0008);
      check("R8 R10 clear and disable", W'(ctrl_status), '0);
      for (int i = 0; i < 2 * T; i++) cyc(0, 0, (i % 7) == 0, '0);
      check("R10 accesses while disabled", W'(ctrl_status[3]), 0);
      cyc(1, 0, 0, 16'h0002);
      idle(T - 1);
      check("R10 re-enable full period", W'(ctrl_status[3]), 0);
      idle(1);
      check("R10 timeout after re-enable", W'(ctrl_status[3]), 1);
      cyc(1, 0, 0, 16'h000A);

      for (int i = 0; i < 4000; i++) begin
         logic cw, dw, dr;
         logic [W-1:0] wd;
         cw = ($urandom % 20) == 0;
         dw = ($urandom % 24) == 0;
         dr = ($urandom % 30) == 0;
         wd = W'($urandom);
         if (cw && ($urandom % 4) != 0) wd[1] = 1'b1;
         cyc(cw, dw, dr, wd);
      end

      idle(2);
      finish_run();
   end
endmodule